// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block is the decision core of one eight-input interrupt controller. It keeps three 8-bit state vectors:
- the pending requests;
- the requests currently being serviced (in-service);
- a per-input mask.

From these it chooses the input that should interrupt the processor next. Priority is circular. A 3-bit pointer names the input with the lowest priority, and the input just after it (wrapping) has the highest. Commands can move that pointer, either directly or as a side effect of ending an interrupt.

Surrounding logic conditions the raw interrupt lines and presents one set strobe per input. It decodes host writes into mask, mode and command strobes. It raises an acknowledge strobe when the processor takes the interrupt. The resolver answers in three ways:
- It drives a held interrupt-request line.
- It registers the currently winning input.
- On each acknowledge, it returns a vector made of a programmable base and the winning pin number. When nothing is eligible at acknowledge time, it returns pin 7 as a spurious vector.

Two modes change how in-service bits hold back requests. In special mask mode, in-service bits are ignored when choosing a winner. In special nested mode, the cascade input's in-service bit does not block; this mode is only available when the block is built as the master.

Top module: `prio_irq_resolver`

## Requirements
- R1: After a synchronous reset, irq_o and win_valid_o are 0, all three state vectors are empty, and the lowest-priority pointer is 7, so pin 0 has the highest priority.
- R2: The winner is found by scanning from pin (pointer+1) mod 8 upward with wrap-around. win_valid_o/win_pin_o show it two clock edges after the state change that caused it. win_pin_o is 0 when win_valid_o is 0.
- R3: An input whose mask bit is 1 never wins, even if its request bit is set.
- R4: An in-service bit stops the scan at its position: requests at the same or lower priority do not win, and higher-priority requests still do.
- R5: While special mask mode is on, in-service bits do not block any request. A non-specific end-of-interrupt in this mode skips in-service bits whose mask bit is 1.
- R6: While special nested mode is on (master build only), the in-service bit of cascade pin 2 does not block requests, and pin 2 itself may win again.
- R7: A command with eoi=1 and select=1 clears the in-service bit named by cmd_pin_i. If rotate=1, the pointer becomes that pin.
- R8: A command with eoi=1 and select=0 clears the highest-priority in-service bit, if there is one. If rotate=1, the pointer becomes that pin.
- R9: A command with eoi=0, select=1 and rotate=1 loads the pointer from cmd_pin_i. With rotate=0, the same command leaves the pointer unchanged. Every command stores its rotate bit for later use by automatic end-of-interrupt.
- R10: On an acknowledge with a winner, the winner's request bit is cleared unless its line_active_i bit is 1. Without automatic end-of-interrupt, the winner's in-service bit is set. With automatic end-of-interrupt, the in-service bit is not set, and if the stored rotate bit is 1 the pointer becomes the winner.
- R11: One edge after an acknowledge, ack_vec_o equals {vec_base_i, pin}, where pin is the winner, or 7 when there is no winner. A spurious acknowledge changes no state.
- R12: irq_o is set one edge after a winner exists. It stays high until an acknowledge, and it is 0 in the cycle after each acknowledge.
- R13: init_i clears the request and mask vectors and special mask mode, and sets the pointer to 7. It keeps the in-service vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_i | input | 1 | Initialization strobe |
| req_set_i | input | 8 | Per-input request set strobes |
| line_active_i | input | 8 | Current active state of each conditioned input |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_data_i | input | 8 | New mask value, 1 = blocked |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_smm_i | input | 1 | Special mask mode value |
| mode_sfn_i | input | 1 | Special nested mode value |
| mode_aeoi_i | input | 1 | Automatic end-of-interrupt value |
| cmd_valid_i | input | 1 | Priority/EOI command strobe |
| cmd_rotate_i | input | 1 | Command rotate bit |
| cmd_select_i | input | 1 | Command specific-pin bit |
| cmd_eoi_i | input | 1 | Command end-of-interrupt bit |
| cmd_pin_i | input | 3 | Command pin operand |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| vec_base_i | input | 5 | Upper bits of the acknowledge vector |
| irq_o | output | 1 | Interrupt request to the processor |
| win_valid_o | output | 1 | A winner exists (registered) |
| win_pin_o | output | 3 | Winning pin (registered) |
| ack_vec_o | output | 8 | Vector returned on the last acknowledge |

## Verification
The assertions assume three things about the inputs:
- Acknowledge, command and init strobes are each one cycle wide.
- An acknowledge does not share a cycle with a command or an init when its in-service effect is checked.
- vec_base_i is stable around an acknowledge.

The stimulus is applied one operation at a time, each on its own falling clock edge, and the bench waits for the outputs to settle before the next step. This keeps every strobe isolated, so the interaction between acknowledge, end-of-interrupt and pointer updates is exercised only in the orders the requirements define.

// File: rtl/prio_irq_pkg.sv
// Shared types for the rotating-priority interrupt resolver.
// Assumes: the pin count is a power of two.
package prio_irq_pkg;

    // Mode bits as written by the mode strobe
    typedef struct packed {
        logic smm;   // in-service bits ignored for selection
        logic sfn;   // cascade in-service bit does not block
        logic aeoi;  // acknowledge does not set in-service
    } prio_mode_t;

    // Decoded priority / end-of-interrupt command
    typedef struct packed {
        logic rotate;
        logic select;
        logic eoi;
    } prio_cmd_t;

endpackage

// File: rtl/prio_rot_scan.sv
// Circular priority scanner.
// Rotates a candidate vector and a stop vector so that pin (lowprio+1)
// lands at index 0. It then takes the first index where either bit is set.
// It reports a hit only when that first index is a candidate and not a stop.
// Assumes: NPIN is a power of two, so pin arithmetic wraps naturally.
module prio_rot_scan #(
    parameter int NPIN = 8,
    localparam int PW = $clog2(NPIN)
) (
    input  logic [NPIN-1:0] cand_i,
    input  logic [NPIN-1:0] stop_i,
    input  logic [PW-1:0]   lowprio_i,
    output logic            hit_o,
    output logic [PW-1:0]   pin_o
);
    logic [PW-1:0]   start;
    logic [NPIN-1:0] rot_cand;
    logic [NPIN-1:0] rot_stop;

    assign start = lowprio_i + PW'(1);

    // Rotation: index g of the rotated vectors is pin (start+g) mod NPIN
    for (genvar g = 0; g < NPIN; g++) begin : g_rot
        logic [PW-1:0] src;
        assign src         = start + PW'(g);
        assign rot_cand[g] = cand_i[src];
        assign rot_stop[g] = stop_i[src];
    end

    // Fixed-priority encoder over the rotated vectors
    always_comb begin
        logic done;
        done  = 1'b0;
        hit_o = 1'b0;
        pin_o = '0;
        for (int i = 0; i < NPIN; i++) begin
            if (!done && (rot_cand[i] || rot_stop[i])) begin
                done  = 1'b1;
                hit_o = rot_cand[i] && !rot_stop[i];
                pin_o = start + PW'(i);
            end
        end
    end
endmodule

// File: rtl/prio_irq_resolver.sv
// Rotating-priority interrupt resolver for one controller.
// Holds request, in-service and mask vectors, a lowest-priority pointer and
// mode bits. It selects a winner, applies end-of-interrupt and
// priority commands, and handles acknowledge.
// Assumes: strobes are one cycle wide; input conditioning and bus decode
// are done outside; NPIN is a power of two.
module prio_irq_resolver
    import prio_irq_pkg::*;
#(
    parameter int NPIN      = 8,
    parameter int VEC_W     = 8,
    parameter int CASC_PIN  = 2,
    parameter bit IS_MASTER = 1'b1,
    localparam int PW       = $clog2(NPIN),
    localparam int BASE_W   = VEC_W - PW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic [NPIN-1:0]   req_set_i,
    input  logic [NPIN-1:0]   line_active_i,
    input  logic              mask_wr_i,
    input  logic [NPIN-1:0]   mask_data_i,
    input  logic              mode_wr_i,
    input  logic              mode_smm_i,
    input  logic              mode_sfn_i,
    input  logic              mode_aeoi_i,
    input  logic              cmd_valid_i,
    input  logic              cmd_rotate_i,
    input  logic              cmd_select_i,
    input  logic              cmd_eoi_i,
    input  logic [PW-1:0]     cmd_pin_i,
    input  logic              ack_i,
    input  logic [BASE_W-1:0] vec_base_i,
    output logic              irq_o,
    output logic              win_valid_o,
    output logic [PW-1:0]     win_pin_o,
    output logic [VEC_W-1:0]  ack_vec_o
);
    localparam logic [NPIN-1:0] CASC_BIT = NPIN'(1) << CASC_PIN;

    logic [NPIN-1:0] irr_q, isr_q, imr_q;
    logic [PW-1:0]   lowprio_q;
    logic            rot_q;
    prio_mode_t      mode_q;
    prio_cmd_t       cmd;
    logic            sfn_allow;

    logic [NPIN-1:0] blk_vec, eoi_cand;
    logic            req_hit, isr_hit;
    logic [PW-1:0]   req_pin, isr_pin;

    logic            eoi_ok, setpri, ack_ok;
    logic [PW-1:0]   eoi_pin;
    logic [NPIN-1:0] eoi_clr, ack_isr_set, ack_irr_clr;

    logic            irq_q, win_valid_q;
    logic [PW-1:0]   win_pin_q;
    logic [VEC_W-1:0] ack_vec_q;

    assign cmd = '{rotate: cmd_rotate_i, select: cmd_select_i, eoi: cmd_eoi_i};

    // Special nested mode exists only on the master build
    if (IS_MASTER) begin : g_sfn_master
        assign sfn_allow = mode_sfn_i;
    end else begin : g_sfn_slave
        assign sfn_allow = 1'b0;
    end

    // Blocking vector for selection: ignored in mask mode, cascade freed in nested mode
    always_comb begin
        if (mode_q.smm)      blk_vec = '0;
        else if (mode_q.sfn) blk_vec = isr_q & ~CASC_BIT;
        else                 blk_vec = isr_q;
    end

    // End-of-interrupt candidates: masked in-service bits skipped in mask mode
    assign eoi_cand = mode_q.smm ? (isr_q & ~imr_q) : isr_q;

    prio_rot_scan #(.NPIN(NPIN)) req_scan_i (
        .cand_i    (irr_q & ~imr_q),
        .stop_i    (blk_vec),
        .lowprio_i (lowprio_q),
        .hit_o     (req_hit),
        .pin_o     (req_pin)
    );

    prio_rot_scan #(.NPIN(NPIN)) isr_scan_i (
        .cand_i    (eoi_cand),
        .stop_i    ('0),
        .lowprio_i (lowprio_q),
        .hit_o     (isr_hit),
        .pin_o     (isr_pin)
    );

    // Command and acknowledge decode into per-pin clear/set vectors
    always_comb begin
        eoi_pin     = cmd.select ? cmd_pin_i : isr_pin;
        eoi_ok      = cmd_valid_i && cmd.eoi && (cmd.select || isr_hit);
        eoi_clr     = eoi_ok ? (NPIN'(1) << eoi_pin) : '0;
        setpri      = cmd_valid_i && !cmd.eoi && cmd.select && cmd.rotate;
        ack_ok      = ack_i && req_hit;
        ack_isr_set = (ack_ok && !mode_q.aeoi) ? (NPIN'(1) << req_pin) : '0;
        ack_irr_clr = (ack_ok && !line_active_i[req_pin]) ? (NPIN'(1) << req_pin) : '0;
    end

    // Controller state: request, in-service, mask, pointer and modes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q     <= '0;
            isr_q     <= '0;
            imr_q     <= '0;
            lowprio_q <= '1;
            rot_q     <= 1'b0;
            mode_q    <= '0;
        end else if (init_i) begin
            irr_q      <= '0;
            imr_q      <= '0;
            lowprio_q  <= '1;
            mode_q.smm <= 1'b0;
        end else begin
            irr_q <= (irr_q & ~ack_irr_clr) | req_set_i;
            isr_q <= (isr_q & ~eoi_clr) | ack_isr_set;
            if (mask_wr_i) imr_q <= mask_data_i;
            if (mode_wr_i) mode_q <= '{smm: mode_smm_i, sfn: sfn_allow, aeoi: mode_aeoi_i};
            if (cmd_valid_i) rot_q <= cmd.rotate;
            if (ack_ok && mode_q.aeoi && rot_q) lowprio_q <= req_pin;
            else if (eoi_ok && cmd.rotate)      lowprio_q <= eoi_pin;
            else if (setpri)                    lowprio_q <= cmd_pin_i;
        end
    end

    // Output registers: request line, registered winner, acknowledge vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q       <= 1'b0;
            win_valid_q <= 1'b0;
            win_pin_q   <= '0;
            ack_vec_q   <= '0;
        end else begin
            if (ack_i)        irq_q <= 1'b0;
            else if (req_hit) irq_q <= 1'b1;
            win_valid_q <= req_hit;
            win_pin_q   <= req_hit ? req_pin : '0;
            if (ack_i) ack_vec_q <= {vec_base_i, (ack_ok ? req_pin : {PW{1'b1}})};
        end
    end

    assign irq_o       = irq_q;
    assign win_valid_o = win_valid_q;
    assign win_pin_o   = win_pin_q;
    assign ack_vec_o   = ack_vec_q;
endmodule

// File: rtl/prio_irq_resolver_chk.sv
// Property checker for prio_irq_resolver, attached by bind.
// Assumes: inputs follow the rules stated in the brief's verification section.
module prio_irq_resolver_chk #(
    parameter int NPIN     = 8,
    parameter int VEC_W    = 8,
    parameter int CASC_PIN = 2,
    localparam int PW      = $clog2(NPIN),
    localparam int BASE_W  = VEC_W - PW
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_i,
    input logic              cmd_valid_i,
    input logic              init_i,
    input logic [BASE_W-1:0] vec_base_i,
    input logic              irq_o,
    input logic              win_valid_o,
    input logic [VEC_W-1:0]  ack_vec_o,
    input logic              req_hit,
    input logic [PW-1:0]     req_pin,
    input logic [NPIN-1:0]   imr_q,
    input logic [NPIN-1:0]   isr_q,
    input logic              smm,
    input logic              sfn,
    input logic              aeoi
);
    // R1: quiet outputs in the first cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!irq_o && !win_valid_o));

    // R3: a masked input is never the winner
    a_r3_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        req_hit |-> !imr_q[req_pin]);

    // R4, R6: winner never has a blocking in-service bit
    a_r4_isr_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (req_hit && !smm) |-> (!isr_q[req_pin] || (sfn && req_pin == PW'(CASC_PIN))));

    // R10: automatic EOI acknowledge leaves the in-service vector alone
    a_r10_aeoi_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && req_hit && aeoi && !cmd_valid_i && !init_i) |=> $stable(isr_q));

    // R11: acknowledge vector carries the base
    a_r11_ack_base: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> (ack_vec_o[VEC_W-1:PW] == $past(vec_base_i)));

    // R11: spurious acknowledge returns pin 7
    a_r11_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !req_hit) |=> (ack_vec_o[PW-1:0] == {PW{1'b1}}));

    // R12: request line drops after acknowledge
    a_r12_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !irq_o);

    // R12: request line held until acknowledge
    a_r12_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i) |=> irq_o);
endmodule

bind prio_irq_resolver prio_irq_resolver_chk #(
    .NPIN(NPIN), .VEC_W(VEC_W), .CASC_PIN(CASC_PIN)
) chk_i (
    .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .cmd_valid_i(cmd_valid_i),
    .init_i(init_i), .vec_base_i(vec_base_i), .irq_o(irq_o),
    .win_valid_o(win_valid_o), .ack_vec_o(ack_vec_o), .req_hit(req_hit),
    .req_pin(req_pin), .imr_q(imr_q), .isr_q(isr_q), .smm(mode_q.smm),
    .sfn(mode_q.sfn), .aeoi(mode_q.aeoi)
);

// File: tb/prio_irq_resolver_tb_top.sv
`timescale 1ns/1ps
module prio_irq_resolver_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_i = 1'b0;
    logic [7:0] req_set_i = '0, line_active_i = '0, mask_data_i = '0;
    logic       mask_wr_i = 1'b0, mode_wr_i = 1'b0;
    logic       mode_smm_i = 1'b0, mode_sfn_i = 1'b0, mode_aeoi_i = 1'b0;
    logic       cmd_valid_i = 1'b0, cmd_rotate_i = 1'b0, cmd_select_i = 1'b0, cmd_eoi_i = 1'b0;
    logic [2:0] cmd_pin_i = '0;
    logic       ack_i = 1'b0;
    logic [4:0] vec_base_i = 5'h11;
    logic       irq_o, win_valid_o;
    logic [2:0] win_pin_o;
    logic [7:0] ack_vec_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    prio_irq_resolver dut_i (.*);

    // Table: {lowprio, mask, requests, expected valid, expected pin}
    localparam int NTBL = 8;
    localparam logic [22:0] TBL [NTBL] = '{
        {3'd7, 8'h00, 8'h0A, 1'b1, 3'd1},
        {3'd7, 8'h02, 8'h0A, 1'b1, 3'd3},
        {3'd2, 8'h00, 8'h0A, 1'b1, 3'd3},
        {3'd3, 8'h00, 8'h0A, 1'b1, 3'd1},
        {3'd7, 8'hFF, 8'hFF, 1'b0, 3'd0},
        {3'd6, 8'h00, 8'h81, 1'b1, 3'd7},
        {3'd0, 8'h00, 8'h81, 1'b1, 3'd7},
        {3'd7, 8'h00, 8'h00, 1'b0, 3'd0}
    };

    task automatic tick(); @(negedge clk); endtask
    task automatic settle(); repeat (2) tick(); endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_win(input string tag, input bit v, input int p);
        settle();
        chk(tag, {win_valid_o, win_pin_o}, {v, p[2:0]});
    endtask

    task automatic do_reset();
        rst_n = 1'b0; repeat (2) tick(); rst_n = 1'b1; tick();
    endtask

    task automatic req(input logic [7:0] b);
        req_set_i = b; tick(); req_set_i = '0;
    endtask

    task automatic set_mask(input logic [7:0] m);
        mask_data_i = m; mask_wr_i = 1'b1; tick(); mask_wr_i = 1'b0;
    endtask

    task automatic set_mode(input bit smm, input bit sfn, input bit aeoi);
        mode_smm_i = smm; mode_sfn_i = sfn; mode_aeoi_i = aeoi;
        mode_wr_i = 1'b1; tick(); mode_wr_i = 1'b0;
    endtask

    task automatic cmd(input bit rot, input bit sel, input bit eoi, input logic [2:0] p);
        cmd_rotate_i = rot; cmd_select_i = sel; cmd_eoi_i = eoi; cmd_pin_i = p;
        cmd_valid_i = 1'b1; tick(); cmd_valid_i = 1'b0;
    endtask

    task automatic do_ack(input string tag, input int exp_vec);
        ack_i = 1'b1; tick(); ack_i = 1'b0;
        chk(tag, ack_vec_o, exp_vec);
        chk({tag, " irq low after ack (R12)"}, irq_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick();
        do_reset();
        // R1: reset state
        chk("R1 irq after reset", irq_o, 0);
        chk("R1 win_valid after reset", win_valid_o, 0);

        // R2, R3, R9: table of priority patterns
        for (int i = 0; i < NTBL; i++) begin
            do_reset();
            if (TBL[i][22:20] != 3'd7) cmd(1'b1, 1'b1, 1'b0, TBL[i][22:20]);
            set_mask(TBL[i][19:12]);
            req(TBL[i][11:4]);
            chk_win($sformatf("R2/R3 table entry %0d", i), TBL[i][3], int'(TBL[i][2:0]));
        end

        // R11: spurious acknowledge, then no state change
        do_reset();
        do_ack("R11 spurious vector", 8'h8F);
        req(8'h80);
        chk_win("R11 spurious ack left pin 7 free", 1'b1, 7);

        // R4, R12: in-service blocking and request line
        do_reset();
        req(8'h08); settle();
        chk("R12 irq raised", irq_o, 1);
        do_ack("R11 vector pin 3", 8'h8B);
        req(8'h20);
        chk_win("R4 lower request blocked", 1'b0, 0);
        chk("R12 irq stays low with no winner", irq_o, 0);
        req(8'h02);
        chk_win("R4 higher request wins", 1'b1, 1);
        chk("R12 irq raised again", irq_o, 1);
        do_ack("R11 vector pin 1", 8'h89);

        // R8: non-specific EOI clears highest in-service bit first
        cmd(1'b0, 1'b0, 1'b1, 3'd0);
        chk_win("R8 first EOI clears pin 1 only", 1'b0, 0);
        cmd(1'b0, 1'b0, 1'b1, 3'd0);
        chk_win("R8 second EOI frees pin 5", 1'b1, 5);

        // R7: specific EOI with rotate moves pointer
        do_ack("R11 vector pin 5", 8'h8D);
        cmd(1'b1, 1'b1, 1'b1, 3'd5);
        req(8'h41);
        chk_win("R7 pointer at 5 makes 6 highest", 1'b1, 6);

        // R9: set priority with and without rotate
        cmd(1'b1, 1'b1, 1'b0, 3'd6);
        chk_win("R9 pointer at 6 makes 0 win", 1'b1, 0);
        cmd(1'b0, 1'b1, 1'b0, 3'd5);
        chk_win("R9 no-rotate command ignored", 1'b1, 0);

        // R10: acknowledge with active line, then automatic EOI
        do_reset();
        vec_base_i = 5'h1F;
        line_active_i = 8'h14;
        req(8'h10);
        do_ack("R11 base field", 8'hFC);
        chk_win("R10 in-service set blocks pin 4", 1'b0, 0);
        cmd(1'b0, 1'b0, 1'b1, 3'd0);
        chk_win("R10 active line keeps request", 1'b1, 4);
        set_mode(1'b0, 1'b0, 1'b1);
        do_ack("R10 auto EOI vector", 8'hFC);
        chk_win("R10 auto EOI sets no in-service", 1'b1, 4);
        cmd(1'b1, 1'b0, 1'b0, 3'd0);
        req(8'h04);
        chk_win("R10 pin 2 wins before rotation", 1'b1, 2);
        do_ack("R10 vector pin 2", 8'hFA);
        chk_win("R10 auto EOI rotation to pin 2", 1'b1, 4);

        // R5: special mask mode
        do_reset();
        vec_base_i = 5'h11;
        line_active_i = 8'h00;
        req(8'h02);
        do_ack("R11 vector pin 1 (smm)", 8'h89);
        req(8'h10);
        chk_win("R5 blocked before mask mode", 1'b0, 0);
        set_mode(1'b1, 1'b0, 1'b0);
        chk_win("R5 mask mode ignores in-service", 1'b1, 4);
        set_mask(8'h02);
        do_ack("R11 vector pin 4 (smm)", 8'h8C);
        cmd(1'b0, 1'b0, 1'b1, 3'd0);
        set_mode(1'b0, 1'b0, 1'b0);
        set_mask(8'h00);
        req(8'h04);
        chk_win("R5 EOI skipped masked in-service pin 1", 1'b0, 0);

        // R6: special nested mode on the cascade pin
        do_reset();
        req(8'h04);
        do_ack("R11 vector pin 2", 8'h8A);
        req(8'h20);
        chk_win("R6 cascade blocks without nested mode", 1'b0, 0);
        set_mode(1'b0, 1'b1, 1'b0);
        chk_win("R6 nested mode frees pin 5", 1'b1, 5);
        req(8'h04);
        chk_win("R6 cascade pin wins again", 1'b1, 2);

        // R13: init clears request, mask, pointer, keeps in-service
        cmd(1'b1, 1'b1, 1'b0, 3'd3);
        set_mask(8'h42);
        init_i = 1'b1; tick(); init_i = 1'b0;
        chk_win("R13 requests cleared", 1'b0, 0);
        set_mode(1'b0, 1'b0, 1'b0);
        req(8'h40);
        chk_win("R13 in-service kept, pointer 7", 1'b0, 0);
        req(8'h02);
        chk_win("R13 mask cleared", 1'b1, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule